// File: doc/BRIEF.md
# Triplex LCD Segment Multiplexer

This block drives a liquid-crystal panel that is multiplexed three ways: three common electrodes (backplanes) and twelve segment lines, plus one annunciator line. Each backplane is selected for one third of the frame. The block takes a 3 3/4 digit reading as input: three BCD digits, a most significant digit limited to 0..3, a sign, a two-bit decimal point code and five status flags (overrange, peak hold, logic high, logic low, low battery). It does the seven-segment decoding, maps each segment onto its line and backplane, and produces the frame timing.

Every backplane and segment output is a two-bit drive-level code from 0 to 3. An external resistor ladder turns each code into one of four bias voltages. The frame is split into six equal slots. In the second half of the frame every level is mirrored, so the panel sees no DC on average. With the default slot length the frame lasts 240 clock cycles. The annunciator line is a square wave at the frame rate. An annunciator segment is switched on by wiring it to this line.

Top module: `trilcd_mux`

## Requirements
- R1: While `rst` is high at a clock edge, `bp_drv`, `seg_drv` and `annunc` are all zero after that edge.
- R2: The outputs are registered. After reset, the frame is six slots of `SLOT_CYCLES` (default 40) edges each, so the frame lasts 240 edges. Edge n after reset (n = 0, 1, ...) outputs slot floor(n/SLOT_CYCLES) mod 6, using the inputs present at that edge.
- R3: Backplane k (k = 0..2, code at `bp_drv[2k+1:2k]`) is driven to level 3 in slot k and to level 0 in slot k+3. In any other slot it is at level 1 during slots 0..2 and at level 2 during slots 3..5. The displayed data never changes these levels.
- R4: In slot s, each segment line shows the segment assigned to backplane s mod 3. In slots 0..2 an on segment is driven to 0 and an off segment to 2. In slots 3..5 an on segment is driven to 3 and an off segment to 1. Line i uses `seg_drv[2i+1:2i]`.
- R5: `annunc` is 1 during slots 0..2 and 0 during slots 3..5.
- R6: Line map, for lines 0..11. Backplane 0 carries: logic-low, a4, b4, logic-high, a3, b3, overrange, a2, b2, peak, a1, b1. Backplane 1 carries: minus, g4, c4, f3, g3, c3, f2, g2, c2, f1, g1, c1. Backplane 2 carries: e4, d4, dp3, e3, d3, dp2, e2, d2, dp1, e1, d1, low battery. Digit 4 is the most significant.
- R7: Digits 1..3 use the usual seven-segment glyphs for BCD 0..9: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg. Codes 10..15 are blank.
- R8: The most significant digit takes a two-bit value: 0 is blank, 1=bc, 2=abdeg, 3=abcdg.
- R9: `dp_sel` selects the decimal point: 00 none, 01 dp1, 10 dp2, 11 dp3.
- R10: When `over_flag` is set, digit 3 shows O (abcdef) and digit 2 shows L (def), digits 4 and 1 are blank, and the overrange annunciator is on. The sign and the decimal point are unaffected.
- R11: The sign, peak, logic-high, logic-low and low-battery inputs each light their own annunciator segment directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the frame is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| msd_val | input | 2 | Most significant digit value, 0..3 |
| d3_bcd | input | 4 | Third digit, BCD |
| d2_bcd | input | 4 | Second digit, BCD |
| d1_bcd | input | 4 | Least significant digit, BCD |
| negative | input | 1 | Lights the minus sign |
| dp_sel | input | 2 | Decimal point code |
| over_flag | input | 1 | Overrange: show OL and the overrange annunciator |
| peak_flag | input | 1 | Peak hold annunciator |
| hi_flag | input | 1 | Logic-high annunciator |
| lo_flag | input | 1 | Logic-low annunciator |
| batt_flag | input | 1 | Low battery annunciator |
| bp_drv | output | 6 | Drive-level codes of the three backplanes, two bits each |
| seg_drv | output | 24 | Drive-level codes of the twelve segment lines, two bits each |
| annunc | output | 1 | Annunciator square wave, in phase with backplane 0 |

## Verification
Every output goes through one register. A change in the digits or flags is therefore visible one edge later, in whichever slot the frame has reached. A slot change appears on the edge numbered by R2 after the previous slot change. The reference model in the bench counts edges since reset. At each rising edge it computes the expected codes from the inputs present at that edge, and it compares all outputs at the following falling edge. No sample is taken while a register is changing. Stimulus changes at falling edges and is often applied mid-frame. This exercises data changes in every slot, and it also confirms that the backplane codes do not follow the data.

// File: rtl/trilcd_pkg.sv
package trilcd_pkg;
  localparam int BP_COUNT   = 3;
  localparam int LINE_COUNT = 12;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LV0 = 2'd0;
  localparam lvl_t LV1 = 2'd1;
  localparam lvl_t LV2 = 2'd2;
  localparam lvl_t LV3 = 2'd3;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
    logic e;
    logic f;
    logic g;
  } seg7_t;

  localparam seg7_t GLYPH_O = 7'b1111110;
  localparam seg7_t GLYPH_L = 7'b0001110;
endpackage

// File: rtl/trilcd_frame_timer.sv
module trilcd_frame_timer #(
  parameter int SLOT_CYCLES = 40,
  parameter int BP_N        = 3,
  localparam int CW         = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1,
  localparam int BPW        = (BP_N > 1) ? $clog2(BP_N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  output logic [BPW-1:0] phase,
  output logic           neg_half
);
  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick     <= '0;
      phase    <= '0;
      neg_half <= 1'b0;
    end else if (tick == CW'(SLOT_CYCLES - 1)) begin
      tick <= '0;
      if (phase == BPW'(BP_N - 1)) begin
        phase    <= '0;
        neg_half <= ~neg_half;
      end else begin
        phase <= phase + 1'b1;
      end
    end else begin
      tick <= tick + 1'b1;
    end
  end
endmodule

// File: rtl/trilcd_digit_dec.sv
module trilcd_digit_dec
  import trilcd_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              blank,
  output seg7_t             seg
);
  seg7_t raw;

  generate
    if (CODE_W == 2) begin : g_msd
      always_comb begin
        case (code)
          2'd1:    raw = 7'b0110000;
          2'd2:    raw = 7'b1101101;
          2'd3:    raw = 7'b1111001;
          default: raw = 7'b0000000;
        endcase
      end
    end else begin : g_bcd
      always_comb begin
        case (code)
          CODE_W'(0): raw = 7'b1111110;
          CODE_W'(1): raw = 7'b0110000;
          CODE_W'(2): raw = 7'b1101101;
          CODE_W'(3): raw = 7'b1111001;
          CODE_W'(4): raw = 7'b0110011;
          CODE_W'(5): raw = 7'b1011011;
          CODE_W'(6): raw = 7'b1011111;
          CODE_W'(7): raw = 7'b1110000;
          CODE_W'(8): raw = 7'b1111111;
          CODE_W'(9): raw = 7'b1111011;
          default:    raw = 7'b0000000;
        endcase
      end
    end
  endgenerate

  assign seg = blank ? 7'b0000000 : raw;
endmodule

// File: rtl/trilcd_seg_map.sv
module trilcd_seg_map
  import trilcd_pkg::*;
(
  input  logic [1:0] msd_val,
  input  logic [3:0] d3_bcd,
  input  logic [3:0] d2_bcd,
  input  logic [3:0] d1_bcd,
  input  logic       negative,
  input  logic [1:0] dp_sel,
  input  logic       over_flag,
  input  logic       peak_flag,
  input  logic       hi_flag,
  input  logic       lo_flag,
  input  logic       batt_flag,
  output logic [BP_COUNT-1:0][LINE_COUNT-1:0] on
);
  localparam int NUM_BCD = 3;

  seg7_t s4, s3, s2, s1;
  seg7_t dec [NUM_BCD];
  logic [3:0] bcd_in [NUM_BCD];
  logic dp1, dp2, dp3;

  assign bcd_in[0] = d1_bcd;
  assign bcd_in[1] = d2_bcd;
  assign bcd_in[2] = d3_bcd;

  generate
    for (genvar i = 0; i < NUM_BCD; i++) begin : g_dec
      trilcd_digit_dec #(.CODE_W(4)) u_dec (
        .code  (bcd_in[i]),
        .blank (over_flag),
        .seg   (dec[i])
      );
    end
  endgenerate

  trilcd_digit_dec #(.CODE_W(2)) u_msd (
    .code  (msd_val),
    .blank (over_flag),
    .seg   (s4)
  );

  assign s1 = dec[0];
  assign s2 = over_flag ? GLYPH_L : dec[1];
  assign s3 = over_flag ? GLYPH_O : dec[2];

  assign dp1 = (dp_sel == 2'b01);
  assign dp2 = (dp_sel == 2'b10);
  assign dp3 = (dp_sel == 2'b11);

  // bit 0 is line 0; each row is one backplane
  assign on[0] = {s1.b, s1.a, peak_flag, s2.b, s2.a, over_flag,
                  s3.b, s3.a, hi_flag, s4.b, s4.a, lo_flag};
  assign on[1] = {s1.c, s1.g, s1.f, s2.c, s2.g, s2.f,
                  s3.c, s3.g, s3.f, s4.c, s4.g, negative};
  assign on[2] = {batt_flag, s1.d, s1.e, dp1, s2.d, s2.e,
                  dp2, s3.d, s3.e, dp3, s4.d, s4.e};
endmodule

// File: rtl/trilcd_line_drv.sv
module trilcd_line_drv
  import trilcd_pkg::*;
#(
  parameter int BP_N   = BP_COUNT,
  parameter int LINE_N = LINE_COUNT,
  localparam int BPW   = (BP_N > 1) ? $clog2(BP_N) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BPW-1:0]               phase,
  input  logic                         neg_half,
  input  logic [BP_N-1:0][LINE_N-1:0]  on,
  output logic [2*BP_N-1:0]            bp_drv,
  output logic [2*LINE_N-1:0]          seg_drv,
  output logic                         annunc
);
  logic [LINE_N-1:0] row;

  always_comb begin
    row = '0;
    for (int k = 0; k < BP_N; k++) begin
      if (phase == BPW'(k)) row = on[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_drv  <= '0;
      seg_drv <= '0;
      annunc  <= 1'b0;
    end else begin
      annunc <= ~neg_half;
      for (int k = 0; k < BP_N; k++) begin
        if (phase == BPW'(k)) bp_drv[2*k +: 2] <= neg_half ? LV0 : LV3;
        else                  bp_drv[2*k +: 2] <= neg_half ? LV2 : LV1;
      end
      for (int i = 0; i < LINE_N; i++) begin
        if (row[i]) seg_drv[2*i +: 2] <= neg_half ? LV3 : LV0;
        else        seg_drv[2*i +: 2] <= neg_half ? LV1 : LV2;
      end
    end
  end
endmodule

// File: rtl/trilcd_mux.sv
module trilcd_mux
  import trilcd_pkg::*;
#(
  parameter int SLOT_CYCLES = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              msd_val,
  input  logic [3:0]              d3_bcd,
  input  logic [3:0]              d2_bcd,
  input  logic [3:0]              d1_bcd,
  input  logic                    negative,
  input  logic [1:0]              dp_sel,
  input  logic                    over_flag,
  input  logic                    peak_flag,
  input  logic                    hi_flag,
  input  logic                    lo_flag,
  input  logic                    batt_flag,
  output logic [2*BP_COUNT-1:0]   bp_drv,
  output logic [2*LINE_COUNT-1:0] seg_drv,
  output logic                    annunc
);
  localparam int BPW = (BP_COUNT > 1) ? $clog2(BP_COUNT) : 1;

  logic [BPW-1:0] phase;
  logic           neg_half;
  logic [BP_COUNT-1:0][LINE_COUNT-1:0] on;

  trilcd_frame_timer #(.SLOT_CYCLES(SLOT_CYCLES), .BP_N(BP_COUNT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .neg_half (neg_half)
  );

  trilcd_seg_map u_map (
    .msd_val   (msd_val),
    .d3_bcd    (d3_bcd),
    .d2_bcd    (d2_bcd),
    .d1_bcd    (d1_bcd),
    .negative  (negative),
    .dp_sel    (dp_sel),
    .over_flag (over_flag),
    .peak_flag (peak_flag),
    .hi_flag   (hi_flag),
    .lo_flag   (lo_flag),
    .batt_flag (batt_flag),
    .on        (on)
  );

  trilcd_line_drv #(.BP_N(BP_COUNT), .LINE_N(LINE_COUNT)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .neg_half (neg_half),
    .on       (on),
    .bp_drv   (bp_drv),
    .seg_drv  (seg_drv),
    .annunc   (annunc)
  );
endmodule

// File: rtl/trilcd_mux_chk.sv
module trilcd_mux_chk
  import trilcd_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [2*BP_COUNT-1:0]   bp_drv,
  input logic [2*LINE_COUNT-1:0] seg_drv,
  input logic                    annunc
);
  logic live;
  logic [BP_COUNT-1:0]   bp_sel;
  logic [BP_COUNT-1:0]   bp_one;
  logic [LINE_COUNT-1:0] seg_odd;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  always_comb begin
    for (int k = 0; k < BP_COUNT; k++) begin
      bp_sel[k] = (bp_drv[2*k +: 2] == LV3) || (bp_drv[2*k +: 2] == LV0);
      bp_one[k] = (bp_drv[2*k +: 2] == LV1);
    end
    for (int i = 0; i < LINE_COUNT; i++) seg_odd[i] = seg_drv[2*i];
  end

  AST_ONE_SELECTED_BP: assert property (@(posedge clk) disable iff (rst || !live)
    $countones(bp_sel) == 1); // R3

  AST_IDLE_BP_POS: assert property (@(posedge clk) disable iff (rst || !live)
    annunc |-> $countones(bp_one) == BP_COUNT - 1); // R3

  AST_SEG_EVEN_POS: assert property (@(posedge clk) disable iff (rst || !live)
    annunc |-> seg_odd == '0); // R4

  AST_SEG_ODD_NEG: assert property (@(posedge clk) disable iff (rst || !live)
    !annunc |-> seg_odd == '1); // R4

  AST_ANN_PHASE_BP0: assert property (@(posedge clk) disable iff (rst || !live)
    annunc |-> bp_drv[1:0] != LV0); // R5

  AST_ANN_RISE_BP0: assert property (@(posedge clk) disable iff (rst || !live)
    $rose(annunc) |-> bp_drv[1:0] == LV3); // R5
endmodule

bind trilcd_mux trilcd_mux_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bp_drv  (bp_drv),
  .seg_drv (seg_drv),
  .annunc  (annunc)
);

// File: tb/trilcd_mux_test.sv
module trilcd_mux_test;
  localparam int SLOT = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  msd_val = '0;
  logic [3:0]  d3_bcd = '0, d2_bcd = '0, d1_bcd = '0;
  logic        negative = 0, over_flag = 0, peak_flag = 0;
  logic        hi_flag = 0, lo_flag = 0, batt_flag = 0;
  logic [1:0]  dp_sel = '0;
  logic [5:0]  bp_drv;
  logic [23:0] seg_drv;
  logic        annunc;

  trilcd_mux #(.SLOT_CYCLES(SLOT)) uut (
    .clk(clk), .rst(rst), .msd_val(msd_val), .d3_bcd(d3_bcd), .d2_bcd(d2_bcd),
    .d1_bcd(d1_bcd), .negative(negative), .dp_sel(dp_sel), .over_flag(over_flag),
    .peak_flag(peak_flag), .hi_flag(hi_flag), .lo_flag(lo_flag),
    .batt_flag(batt_flag), .bp_drv(bp_drv), .seg_drv(seg_drv), .annunc(annunc)
  );

  int checks = 0, failures = 0;
  bit done = 0, running = 0;
  string tag = "R1";

  // reference model state
  int          mcnt = 0;
  logic [5:0]  exp_bp = '0, nb;
  logic [23:0] exp_seg = '0, ns;
  logic        exp_ann = 0, na;

  // returns {a,b,c,d,e,f,g}
  function automatic logic [6:0] bcd_glyph(int v);
    case (v)
      0: return 7'b1111110;  1: return 7'b0110000;  2: return 7'b1101101;
      3: return 7'b1111001;  4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b1011111;  7: return 7'b1110000;  8: return 7'b1111111;
      9: return 7'b1111011;  default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [6:0] digit_segs(int di);
    if (di == 4) begin
      if (over_flag || msd_val == 0) return 7'b0;
      return bcd_glyph(int'(msd_val));
    end
    if (di == 3) return over_flag ? 7'b1111110 : bcd_glyph(int'(d3_bcd));
    if (di == 2) return over_flag ? 7'b0001110 : bcd_glyph(int'(d2_bcd));
    return over_flag ? 7'b0 : bcd_glyph(int'(d1_bcd));
  endfunction

  // letter index: 0=a .. 6=g
  function automatic bit seg_of(int di, int letter);
    logic [6:0] s = digit_segs(di);
    return s[6 - letter];
  endfunction

  function automatic bit dp_on(int n);
    return int'(dp_sel) == n;
  endfunction

  function automatic bit seg_ref(int bp, int line);
    int grp, di, pos;
    if (line == 0)  return (bp == 0) ? lo_flag : (bp == 1) ? negative : seg_of(4, 4);
    if (line == 11) return (bp == 0) ? seg_of(1, 1) : (bp == 1) ? seg_of(1, 2) : batt_flag;
    grp = (line - 1) / 3; di = 4 - grp; pos = (line - 1) % 3;
    if (pos == 0) return seg_of(di, (bp == 0) ? 0 : (bp == 1) ? 6 : 3);
    if (pos == 1) return (bp == 0) ? seg_of(di, 1) : (bp == 1) ? seg_of(di, 2) : dp_on(di - 1);
    if (bp == 0) return (line == 3) ? hi_flag : (line == 6) ? over_flag : peak_flag;
    return seg_of(di - 1, (bp == 1) ? 5 : 4);
  endfunction

  task automatic model(input int cnt, output logic [5:0] b, output logic [23:0] s,
                       output logic a);
    int slot = (cnt / SLOT) % 6;
    bit neg = slot >= 3;
    int act = slot % 3;
    for (int k = 0; k < 3; k++)
      b[2*k +: 2] = (k == act) ? (neg ? 2'd0 : 2'd3) : (neg ? 2'd2 : 2'd1);
    for (int i = 0; i < 12; i++)
      s[2*i +: 2] = seg_ref(act, i) ? (neg ? 2'd3 : 2'd0) : (neg ? 2'd1 : 2'd2);
    a = !neg;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mcnt <= 0; exp_bp <= '0; exp_seg <= '0; exp_ann <= 1'b0;
    end else begin
      model(mcnt, nb, ns, na);
      exp_bp <= nb; exp_seg <= ns; exp_ann <= na;
      mcnt <= mcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      checks++;
      if (bp_drv !== exp_bp || annunc !== exp_ann) begin
        failures++;
        $display("FAIL %s R2/R3/R5 bp=%h ann=%b expected bp=%h ann=%b",
                 rst ? "R1" : "timing", bp_drv, annunc, exp_bp, exp_ann);
      end else if (seg_drv !== exp_seg) begin
        failures++;
        $display("FAIL R4 %s seg=%h expected %h", tag, seg_drv, exp_seg);
      end
    end
  end

  task automatic run(input string t, input int cyc);
    tag = t;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic set_digits(input int m, input int a, input int b, input int c);
    msd_val = 2'(m); d3_bcd = 4'(a); d2_bcd = 4'(b); d1_bcd = 4'(c);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bp_drv !== '0 || seg_drv !== '0 || annunc !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset bp=%h seg=%h ann=%b expected 0 0 0", bp_drv, seg_drv, annunc);
    end
    running = 1;
    rst = 0;
    set_digits(0, 0, 1, 2);          run("R7 R8 digits 0 1 2", 250);
    set_digits(1, 3, 4, 5);          run("R7 R8 digits 3 4 5", 250);
    set_digits(2, 6, 7, 8);          run("R7 R8 digits 6 7 8", 130);
    set_digits(3, 9, 9, 9);          run("R7 R8 digits 9 9 9", 250);
    set_digits(3, 10, 12, 15);       run("R7 invalid BCD blank", 250);
    set_digits(1, 2, 3, 4);
    dp_sel = 2'b01;                  run("R9 dp1", 120);
    dp_sel = 2'b10;                  run("R9 dp2", 120);
    dp_sel = 2'b11;                  run("R9 dp3", 250);
    negative = 1; over_flag = 1; dp_sel = 2'b10;
                                     run("R10 overrange", 250);
    over_flag = 0;
    peak_flag = 1;                   run("R11 peak", 90);
    peak_flag = 0; hi_flag = 1;      run("R11 high", 90);
    hi_flag = 0; lo_flag = 1;        run("R11 low", 90);
    lo_flag = 0; batt_flag = 1;      run("R11 battery", 250);
    negative = 0; batt_flag = 0;     run("R11 flags cleared", 120);
    lo_flag = 1; hi_flag = 1; peak_flag = 1; batt_flag = 1; negative = 1;
    set_digits(3, 8, 8, 8); dp_sel = 2'b11;
                                     run("R6 all segments lit", 250);
    set_digits(0, 1, 1, 1); lo_flag = 0; hi_flag = 0;
                                     run("R6 sparse pattern", 250);
    rst = 1;                         run("R1 reset mid frame", 3);
    rst = 0;                         run("R2 restart frame", 500);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule